// File: doc/BRIEF.md
# Sixteen-Pin GPIO Port with Atomic Bit Aliases

This block is one general-purpose I/O port. It sits behind a simple 32-bit register bus and controls up to `NPINS` pads. Each pin can be analog or digital, input or output, and open-drain or push-pull. Each pin also has a pull-up enable and a pull-down enable. The port also samples the pad inputs through a two-flop synchroniser.

Every register group has four views:
- A raw view, which is read and written normally.
- Clear, set and invert aliases. A write to one of these changes only the bits that are 1 in the written mask.

Because of the aliases, software can flip one pin without a read-modify-write sequence. The port fills the bottom half of a 256-byte window. Each group takes 16 bytes.

The bus has no back-pressure: every access completes in the cycle it is presented. Read data is registered and appears on `bus_rdata` one cycle after the read. It holds until the next read.

Top module: `gpio_atom_port`

## Requirements
- R1: After reset, the analog-select and direction groups are all ones. The latch, open-drain, pull-up, pull-down and change-control groups are all zeros. No pad is driven.
- R2: A byte address selects the group with bits [6:4], in this order: analog 0, direction 1, pin 2, latch 3, open-drain 4, pull-up 5, pull-down 6, change-control 7. Bits [3:2] select the view: raw 0, clear 1, set 2, invert 3. Bits [1:0] are ignored. When bit 7 is 1, writes have no effect and reads return 0.
- R3: A raw write replaces the low `NPINS` bits of the group, and higher data bits are ignored. A read of any view returns the raw value, zero-extended, on `bus_rdata` in the cycle after the read.
- R4: A write to the clear view zeroes the bits that are 1 in the data and leaves the other bits alone.
- R5: A write to the set view sets the bits that are 1 in the data and leaves the other bits alone.
- R6: A write to the invert view toggles the bits that are 1 in the data and leaves the other bits alone.
- R7: A read of the pin group returns the pad inputs after two synchronising flops for digital pins, and 0 for analog pins.
- R8: A write to any view of the pin group acts on the latch exactly as the same view of the latch group would.
- R9: `pad_oe` of a pin is 1 only when its analog bit is 0 and its direction bit is 0. For a push-pull pin, `pad_out` equals the latch bit.
- R10: On an open-drain pin, the pad is driven only while the latch bit is 0, and `pad_out` is then 0. A latch bit of 1 releases the pad.
- R11: `pad_ana`, `pad_od`, `pad_pu` and `pad_pd` equal the analog, open-drain, pull-up and pull-down groups.
- R12: The change-control group keeps whatever its four views write. It has no effect on any pad output.
- R13: With `bus_sel` low, or with `bus_wr` low, no register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address within the port window |
| bus_wdata | input | 32 | Write data or bit mask |
| bus_rdata | output | 32 | Registered read data |
| pad_in | input | 16 | Asynchronous pad input levels |
| pad_oe | output | 16 | Per-pin output enable |
| pad_out | output | 16 | Per-pin output level |
| pad_od | output | 16 | Per-pin open-drain mode |
| pad_pu | output | 16 | Per-pin pull-up enable |
| pad_pd | output | 16 | Per-pin pull-down enable |
| pad_ana | output | 16 | Per-pin analog mode |

## Verification
The alias properties assume the following about the bus:
- Address and data are stable across the sampling edge of any cycle with `bus_sel` high.
- A read is a separate cycle from a write, so the read data always reflects the state before that edge.

The bench drives every bus signal on the falling edge and holds one access per cycle. It changes `pad_in` only while no read is in flight. It then waits three cycles before reading the pin group, so the synchroniser has settled and the sampled level is well defined.

// File: rtl/gpio_atom_pkg.sv
package gpio_atom_pkg;
  localparam int NGRP = 8;

  typedef enum logic [2:0] {
    G_ANA = 3'd0,
    G_DIR = 3'd1,
    G_PIN = 3'd2,
    G_LAT = 3'd3,
    G_ODC = 3'd4,
    G_PUP = 3'd5,
    G_PDN = 3'd6,
    G_CNC = 3'd7
  } grp_e;

  typedef enum logic [1:0] {
    V_RAW = 2'd0,
    V_CLR = 2'd1,
    V_SET = 2'd2,
    V_INV = 2'd3
  } view_e;
endpackage

// File: rtl/gpio_atom_sync.sv
module gpio_atom_sync #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/gpio_atom_decode.sv
module gpio_atom_decode
  import gpio_atom_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-3:0] waddr,
  output logic [NGRP-1:0]   wr_hit,
  output grp_e              grp,
  output view_e             view,
  output logic              in_map
);
  always_comb begin
    view   = view_e'(waddr[1:0]);
    grp    = grp_e'(waddr[4:2]);
    in_map = (waddr[ADDR_W-3:5] == '0);
    wr_hit = '0;
    if (bus_sel && bus_wr && in_map)
      wr_hit[grp] = 1'b1;
  end
endmodule

// File: rtl/gpio_atom_reg.sv
module gpio_atom_reg
  import gpio_atom_pkg::*;
#(
  parameter int           W   = 16,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  view_e        view,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] nxt;

  always_comb begin
    unique case (view)
      V_RAW:   nxt = d;
      V_CLR:   nxt = q & ~d;
      V_SET:   nxt = q | d;
      default: nxt = q ^ d;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= RST;
    else if (we) q <= nxt;
  end
endmodule

// File: rtl/gpio_atom_port.sv
module gpio_atom_port
  import gpio_atom_pkg::*;
#(
  parameter int NPINS  = 16,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NPINS-1:0]  pad_in,
  output logic [NPINS-1:0]  pad_oe,
  output logic [NPINS-1:0]  pad_out,
  output logic [NPINS-1:0]  pad_od,
  output logic [NPINS-1:0]  pad_pu,
  output logic [NPINS-1:0]  pad_pd,
  output logic [NPINS-1:0]  pad_ana
);
  logic [NGRP-1:0]  wr_hit;
  grp_e             grp;
  view_e            view;
  logic             in_map;
  logic [NPINS-1:0] grp_q [NGRP];
  logic [NPINS-1:0] pin_sync;
  logic [NPINS-1:0] lat_q;
  logic [NPINS-1:0] pup_q;
  logic             unused_hi;

  assign unused_hi = ^{bus_wdata[DATA_W-1:NPINS], bus_addr[1:0]};

  gpio_atom_decode #(.ADDR_W(ADDR_W)) u_dec (
    .bus_sel (bus_sel),
    .bus_wr  (bus_wr),
    .waddr   (bus_addr[ADDR_W-1:2]),
    .wr_hit  (wr_hit),
    .grp     (grp),
    .view    (view),
    .in_map  (in_map)
  );

  gpio_atom_sync #(.W(NPINS)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pad_in),
    .q     (pin_sync)
  );

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    if (g == int'(G_PIN)) begin : g_pin
      assign grp_q[g] = pin_sync & ~grp_q[int'(G_ANA)];
    end else begin : g_store
      localparam logic [NPINS-1:0] RV =
        (g == int'(G_ANA) || g == int'(G_DIR)) ? {NPINS{1'b1}} : {NPINS{1'b0}};
      logic we;
      if (g == int'(G_LAT)) begin : g_lat_we
        assign we = wr_hit[g] | wr_hit[int'(G_PIN)];
      end else begin : g_we
        assign we = wr_hit[g];
      end
      gpio_atom_reg #(.W(NPINS), .RST(RV)) u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (we),
        .view  (view),
        .d     (bus_wdata[NPINS-1:0]),
        .q     (grp_q[g])
      );
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      bus_rdata <= '0;
    else if (bus_sel && !bus_wr)
      bus_rdata <= in_map ? DATA_W'(grp_q[grp]) : '0;
  end

  assign lat_q   = grp_q[int'(G_LAT)];
  assign pup_q   = grp_q[int'(G_PUP)];
  assign pad_ana = grp_q[int'(G_ANA)];
  assign pad_od  = grp_q[int'(G_ODC)];
  assign pad_pu  = pup_q;
  assign pad_pd  = grp_q[int'(G_PDN)];
  assign pad_oe  = ~pad_ana & ~grp_q[int'(G_DIR)] & ~(pad_od & lat_q);
  assign pad_out = lat_q & ~pad_od;
endmodule

// File: rtl/gpio_atom_chk.sv
module gpio_atom_chk #(
  parameter int NPINS  = 16,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-3:0] waddr,
  input logic [NPINS-1:0]  wdata,
  input logic [NPINS-1:0]  rdata,
  input logic [NPINS-1:0]  pad_oe,
  input logic [NPINS-1:0]  pad_od,
  input logic [NPINS-1:0]  pad_ana,
  input logic [NPINS-1:0]  lat_q,
  input logic [NPINS-1:0]  pup_q
);
  a_r9_oe_only_digital: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & pad_ana) == '0);

  a_r10_od_drives_low_only: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & pad_od & lat_q) == '0);

  a_r5_set_latch: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && waddr == (ADDR_W-2)'(14))
    |=> lat_q == ($past(lat_q) | $past(wdata)));

  a_r6_invert_latch: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && waddr == (ADDR_W-2)'(15))
    |=> lat_q == ($past(lat_q) ^ $past(wdata)));

  a_r4_clear_pullup: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && waddr == (ADDR_W-2)'(21))
    |=> pup_q == ($past(pup_q) & ~$past(wdata)));

  a_r13_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && bus_wr) |=> ($stable(lat_q) && $stable(pup_q)));

  a_r7_analog_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && waddr == (ADDR_W-2)'(8))
    |=> (rdata & $past(pad_ana)) == '0);
endmodule

bind gpio_atom_port gpio_atom_chk #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .bus_sel (bus_sel),
  .bus_wr  (bus_wr),
  .waddr   (bus_addr[ADDR_W-1:2]),
  .wdata   (bus_wdata[NPINS-1:0]),
  .rdata   (bus_rdata[NPINS-1:0]),
  .pad_oe  (pad_oe),
  .pad_od  (pad_od),
  .pad_ana (pad_ana),
  .lat_q   (lat_q),
  .pup_q   (pup_q)
);

// File: tb/sim_gpio_atom_port.sv
`timescale 1ns/1ps
module sim_gpio_atom_port;
  localparam int N = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [N-1:0] pad_in = '0;
  logic [N-1:0] pad_oe, pad_out, pad_od, pad_pu, pad_pd, pad_ana;

  logic [N-1:0] mdl [8];
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  gpio_atom_port u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out), .pad_od(pad_od),
    .pad_pu(pad_pu), .pad_pd(pad_pd), .pad_ana(pad_ana)
  );

  task automatic chk(input string tag, input logic [95:0] act, input logic [95:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [N-1:0] apply(input logic [N-1:0] old, input int v,
                                         input logic [N-1:0] d);
    case (v)
      0: return d;
      1: return old & ~d;
      2: return old | d;
      default: return old ^ d;
    endcase
  endfunction

  task automatic wr_addr(input logic [7:0] a, input logic [31:0] d, input bit s = 1'b1,
                         input bit w = 1'b1);
    @(negedge clk);
    bus_sel = s; bus_wr = w; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic wr_reg(input int g, input int v, input logic [31:0] d);
    int tgt;
    wr_addr({1'b0, 3'(g), 2'(v), 2'b00}, d);
    tgt = (g == 2) ? 3 : g;
    mdl[tgt] = apply(mdl[tgt], v, d[N-1:0]);
  endtask

  task automatic rd_addr(input logic [7:0] a, output logic [31:0] r);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    r = bus_rdata;
  endtask

  function automatic logic [31:0] exp_rd(input int g);
    if (g == 2) return {16'h0, pad_in & ~mdl[0]};
    return {16'h0, mdl[g]};
  endfunction

  task automatic chk_pads(input string tag);
    logic [N-1:0] eoe, eout;
    eoe  = ~mdl[0] & ~mdl[1] & ~(mdl[4] & mdl[3]);
    eout = mdl[3] & ~mdl[4];
    chk(tag, {pad_oe, pad_out, pad_od, pad_pu, pad_pd, pad_ana},
             {eoe, eout, mdl[4], mdl[5], mdl[6], mdl[0]});
  endtask

  function automatic logic [31:0] pat(input int k);
    return 32'(32'h9E37_79B9 * (k + 3)) ^ 32'(k << 9);
  endfunction

  initial begin
    #1_500_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    string tg;
    mdl[0] = '1; mdl[1] = '1;
    for (int i = 2; i < 8; i++) mdl[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 / R3: reset values through all four views
    chk_pads("R1 reset pads");
    for (int g = 0; g < 8; g++)
      for (int v = 0; v < 4; v++) begin
        rd_addr({1'b0, 3'(g), 2'(v), 2'b00}, r);
        chk("R1 reset readback", {64'h0, r}, {64'h0, exp_rd(g)});
      end

    // Sweep every group through every view
    for (int g = 0; g < 8; g++)
      for (int v = 0; v < 4; v++)
        for (int p = 0; p < 3; p++) begin
          wr_reg(g, v, pat(g * 16 + v * 4 + p));
          case (v)
            0: tg = "R3 raw";
            1: tg = "R4 clear";
            2: tg = "R5 set";
            default: tg = "R6 invert";
          endcase
          if (g == 2) tg = {tg, " R8 pin->latch"};
          if (g == 7) tg = {tg, " R12 change-ctl"};
          chk_pads({tg, " R9 R10 R11 pads"});
          rd_addr({1'b0, (g == 2) ? 3'd3 : 3'(g), 2'(p), 2'b00}, r);
          chk({tg, " readback"}, {64'h0, r}, {64'h0, exp_rd((g == 2) ? 3 : g)});
        end

    // R10: open-drain on half the pins, digital outputs everywhere
    wr_reg(0, 0, 0); wr_reg(1, 0, 0); wr_reg(4, 0, 32'h0000_00FF);
    for (int k = 0; k < 4; k++) begin
      wr_reg(3, 0, pat(k + 70));
      chk_pads("R10 open-drain");
    end

    // R7: synchronised pin reads, mixed analog selection
    for (int k = 0; k < 6; k++) begin
      wr_reg(0, 0, pat(k + 90) >> 8);
      @(negedge clk);
      pad_in = pat(k + 120)[N-1:0];
      repeat (3) @(negedge clk);
      rd_addr(8'h20, r);
      chk("R7 pin read", {64'h0, r}, {64'h0, exp_rd(2)});
    end

    // R2: out-of-map writes ignored, reads zero; low address bits ignored
    wr_addr(8'hB8, 32'hFFFF_FFFF);
    wr_addr(8'hD4, 32'hFFFF_FFFF);
    for (int g = 0; g < 8; g++) begin
      rd_addr({1'b0, 3'(g), 4'b0000}, r);
      chk("R2 out-of-map write ignored", {64'h0, r}, {64'h0, exp_rd(g)});
    end
    rd_addr(8'h90, r);
    chk("R2 out-of-map read", {64'h0, r}, 96'h0);
    wr_addr(8'h3B, 32'h0000_0F0F);
    mdl[3] = mdl[3] | 16'h0F0F;
    rd_addr(8'h31, r);
    chk("R2 low bits ignored", {64'h0, r}, {64'h0, exp_rd(3)});

    // R13: no select, or select without write, changes nothing
    wr_addr(8'h58, 32'h0000_FFFF, 1'b0, 1'b1);
    wr_addr(8'h38, 32'h0000_FFFF, 1'b1, 1'b0);
    chk_pads("R13 no write");
    rd_addr(8'h30, r);
    chk("R13 latch held", {64'h0, r}, {64'h0, exp_rd(3)});

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule